// File: doc/BRIEF.md
# Mirrored Error Status and Alert Controller

This block gathers error events into two independent status registers, one for each of two management controllers. The events are thermal over-limit conditions, voltage violations, general-purpose fault inputs, fan faults and a thermal-trip signal. Every event sets its bit in both copies. Each controller clears bits only in its own copy, by writing ones, so one controller acknowledging an event never hides it from the other.

An active-low open-drain alert line is driven from the primary (copy A) side. It is modelled here as a drive-low enable. Whether an event can raise the alert depends on three things: its own mask bit, a category mask set chosen by the current sleep-state code, and thermal-trip suppression. While thermal trip is active, every other event is kept off the alert.

The alert runs in one of two modes. In interrupt mode it is latched from the status copy. In comparator mode, thermal sources follow their live condition, while non-thermal sources still latch as in interrupt mode.

Top module: `err_mirror_alert`

## Requirements
- R1: An event input that is high at a clock edge sets its status bit in both copies at that edge.
- R2: Writing ones with a copy's clear strobe clears those bits in that copy only; the other copy is unchanged. If an event and a clear of the same bit fall in one cycle, the event wins and the bit stays set.
- R3: A synchronous active-high reset clears both copies and releases the alert line.
- R4: Setting an event's bit in the per-event mask stops that event from asserting the alert. The event is still recorded in both status copies, and removing the mask asserts the alert at the next edge.
- R5: In interrupt mode, the alert stays asserted while any unmasked bit of copy A is set. It releases on the edge that clears the last such bit. The contents of copy B have no effect on the alert.
- R6: When the comparator-mode input is 1, thermal bits drive the alert from their live condition. The alert releases on the first edge at which the condition is low, even though the thermal status bit stays latched.
- R7: In comparator mode, non-thermal events still latch the alert until they are cleared in copy A.
- R8: While the thermal-trip input is high, every event except thermal trip itself is masked from the alert. Thermal trip is recorded in the top status bit and asserts the alert unless its own mask bit is set.
- R9: The sleep-state code selects the category mask set as follows. Code 0 uses no mask. Code 1 uses sleep_mask[2:0], code 2 uses sleep_mask[5:3], and code 3 uses sleep_mask[8:6]. Within each set, bit 0 masks GPI events, bit 1 masks fan events and bit 2 masks temperature and voltage events. The trip bit is never sleep-masked.
- R10: The status bit layout is fixed, starting from bit 0: thermal bits [NT-1:0], then voltage bits, then GPI bits, then fan bits, with thermal trip in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_cond | input | NT | Thermal over-limit conditions, one per zone |
| volt_evt | input | NV | Voltage limit violations |
| gpi_evt | input | NG | General-purpose fault inputs |
| fan_evt | input | NF | Fan fault events |
| trip_in | input | 1 | Thermal trip |
| sleep_code | input | 2 | Current sleep state: 0 run, 1, 2, 3 |
| evt_mask | input | NT+NV+NG+NF+1 | Per-event alert mask, same layout as status |
| sleep_mask | input | 9 | Three category mask sets, one per sleep code 1..3 |
| cmp_mode | input | 1 | 1 selects comparator mode for thermal sources |
| a_clr_we | input | 1 | Clear strobe for copy A |
| a_clr_bits | input | NT+NV+NG+NF+1 | Write-one-to-clear bits for copy A |
| b_clr_we | input | 1 | Clear strobe for copy B |
| b_clr_bits | input | NT+NV+NG+NF+1 | Write-one-to-clear bits for copy B |
| stat_a | output | NT+NV+NG+NF+1 | Status copy A (primary controller) |
| stat_b | output | NT+NV+NG+NF+1 | Status copy B (secondary controller) |
| alert_low_en | output | 1 | Drive-low enable for the open-drain alert |

## Verification
A status bit stuck or wrongly cleared inside one copy appears on that copy's port at the edge after the stimulus. It shows as a mismatch between stat_a and stat_b after an event that should have been mirrored. A wrong mask selection or a wrong mode path shows on alert_low_en at the same edge that records the event, or at the edge where a mask, sleep code or trip level changes. The alert is therefore checked at the edge after every step, not only after clears. A clear routed to the wrong copy is visible at the next edge as a bit missing from the copy that was not written.

// File: rtl/emsa_pkg.sv
package emsa_pkg;
  typedef enum logic [1:0] {
    SLP_RUN = 2'd0,
    SLP_L1  = 2'd1,
    SLP_L3  = 2'd2,
    SLP_L45 = 2'd3
  } slp_e;

  localparam int CAT_GPI = 0;
  localparam int CAT_FAN = 1;
  localparam int CAT_TV  = 2;
  localparam int CAT_W   = 3;
  localparam int SLP_SETS = 3;
endpackage

// File: rtl/em_status_bank.sv
module em_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_n
);
  logic [W-1:0] clr_eff;

  // events win over a simultaneous clear
  always_comb begin
    clr_eff = clr_we ? clr_vec : '0;
    stat_n  = (stat_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_n;
  end
endmodule

// File: rtl/em_mask_gen.sv
module em_mask_gen
  import emsa_pkg::*;
#(
  parameter int NT = 4,
  parameter int NV = 4,
  parameter int NG = 2,
  parameter int NF = 4,
  localparam int W = NT + NV + NG + NF + 1
) (
  input  logic [1:0]                sleep_code,
  input  logic [CAT_W*SLP_SETS-1:0] sleep_mask,
  input  logic [W-1:0]              evt_mask,
  input  logic                      trip_in,
  output logic [W-1:0]              eff_mask
);
  logic [CAT_W-1:0] cat;
  logic [W-1:0]     slp_vec;
  logic [W-1:0]     trip_vec;

  always_comb begin
    unique case (slp_e'(sleep_code))
      SLP_L1:  cat = sleep_mask[0*CAT_W +: CAT_W];
      SLP_L3:  cat = sleep_mask[1*CAT_W +: CAT_W];
      SLP_L45: cat = sleep_mask[2*CAT_W +: CAT_W];
      default: cat = '0;
    endcase
    slp_vec  = {1'b0, {NF{cat[CAT_FAN]}}, {NG{cat[CAT_GPI]}},
                {(NT + NV){cat[CAT_TV]}}};
    trip_vec = {1'b0, {(W - 1){trip_in}}};
    eff_mask = evt_mask | slp_vec | trip_vec;
  end
endmodule

// File: rtl/em_alert_drv.sv
module em_alert_drv #(
  parameter int NT = 4,
  parameter int W  = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  stat_next,
  input  logic [NT-1:0] live_temp,
  input  logic [W-1:0]  eff_mask,
  input  logic          cmp_mode,
  output logic          alert_q
);
  logic [W-1:0]  cmp_sel;
  logic [W-1:0]  latched_src;
  logic [NT-1:0] live_src;
  logic          req;

  always_comb begin
    cmp_sel          = '0;
    cmp_sel[NT-1:0]  = {NT{cmp_mode}};
    latched_src      = stat_next & ~eff_mask & ~cmp_sel;
    live_src         = live_temp & ~eff_mask[NT-1:0] & {NT{cmp_mode}};
    req              = (|latched_src) | (|live_src);
  end

  always_ff @(posedge clk) begin
    if (rst) alert_q <= 1'b0;
    else     alert_q <= req;
  end
endmodule

// File: rtl/err_mirror_alert.sv
module err_mirror_alert
  import emsa_pkg::*;
#(
  parameter int NT = 4,
  parameter int NV = 4,
  parameter int NG = 2,
  parameter int NF = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NT-1:0]          temp_cond,
  input  logic [NV-1:0]          volt_evt,
  input  logic [NG-1:0]          gpi_evt,
  input  logic [NF-1:0]          fan_evt,
  input  logic                   trip_in,
  input  logic [1:0]             sleep_code,
  input  logic [NT+NV+NG+NF:0]   evt_mask,
  input  logic [8:0]             sleep_mask,
  input  logic                   cmp_mode,
  input  logic                   a_clr_we,
  input  logic [NT+NV+NG+NF:0]   a_clr_bits,
  input  logic                   b_clr_we,
  input  logic [NT+NV+NG+NF:0]   b_clr_bits,
  output logic [NT+NV+NG+NF:0]   stat_a,
  output logic [NT+NV+NG+NF:0]   stat_b,
  output logic                   alert_low_en
);
  localparam int W      = NT + NV + NG + NF + 1;
  localparam int COPIES = 2;

  logic [W-1:0] evt_vec;
  logic [W-1:0] eff_mask;
  logic         clr_we_c [COPIES];
  logic [W-1:0] clr_c    [COPIES];
  logic [W-1:0] stq      [COPIES];
  logic [W-1:0] stn      [COPIES];

  // layout R10: temp, volt, gpi, fan, trip (top)
  assign evt_vec = {trip_in, fan_evt, gpi_evt, volt_evt, temp_cond};

  assign clr_we_c[0] = a_clr_we;
  assign clr_c[0]    = a_clr_bits;
  assign clr_we_c[1] = b_clr_we;
  assign clr_c[1]    = b_clr_bits;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    em_status_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_vec (evt_vec),
      .clr_we  (clr_we_c[c]),
      .clr_vec (clr_c[c]),
      .stat_q  (stq[c]),
      .stat_n  (stn[c])
    );
  end

  em_mask_gen #(.NT(NT), .NV(NV), .NG(NG), .NF(NF)) u_mask (
    .sleep_code (sleep_code),
    .sleep_mask (sleep_mask),
    .evt_mask   (evt_mask),
    .trip_in    (trip_in),
    .eff_mask   (eff_mask)
  );

  em_alert_drv #(.NT(NT), .W(W)) u_alert (
    .clk       (clk),
    .rst       (rst),
    .stat_next (stn[0]),
    .live_temp (temp_cond),
    .eff_mask  (eff_mask),
    .cmp_mode  (cmp_mode),
    .alert_q   (alert_low_en)
  );

  assign stat_a = stq[0];
  assign stat_b = stq[1];
endmodule

// File: rtl/em_mirror_chk.sv
module em_mirror_chk #(
  parameter int NT = 4,
  parameter int NV = 4,
  parameter int NG = 2,
  parameter int NF = 4,
  localparam int W = NT + NV + NG + NF + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [NT-1:0] temp_cond,
  input logic [NV-1:0] volt_evt,
  input logic [NG-1:0] gpi_evt,
  input logic [NF-1:0] fan_evt,
  input logic          trip_in,
  input logic          a_clr_we,
  input logic          b_clr_we,
  input logic [W-1:0]  stat_a,
  input logic [W-1:0]  stat_b,
  input logic          alert_low_en
);
  logic [W-1:0] ev;
  assign ev = {trip_in, fan_evt, gpi_evt, volt_evt, temp_cond};

  a_r1_both_set: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> (((stat_a & $past(ev)) == $past(ev)) &&
               ((stat_b & $past(ev)) == $past(ev))));

  a_r1_copies_track: assert property (@(posedge clk) disable iff (rst)
    (!a_clr_we && !b_clr_we && stat_a == stat_b) |=> (stat_a == stat_b));

  a_r2_b_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    !b_clr_we |=> ((stat_b & $past(stat_b)) == $past(stat_b)));

  a_r2_a_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    !a_clr_we |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  a_r3_reset_clear: assert property (@(posedge clk)
    rst |=> (stat_a == '0 && stat_b == '0 && !alert_low_en));

  a_r5_alert_needs_status: assert property (@(posedge clk) disable iff (rst)
    alert_low_en |-> (stat_a != '0));

  a_r8_trip_recorded: assert property (@(posedge clk) disable iff (rst)
    trip_in |=> (stat_a[W-1] && stat_b[W-1]));
endmodule

bind err_mirror_alert em_mirror_chk #(.NT(NT), .NV(NV), .NG(NG), .NF(NF)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .temp_cond    (temp_cond),
  .volt_evt     (volt_evt),
  .gpi_evt      (gpi_evt),
  .fan_evt      (fan_evt),
  .trip_in      (trip_in),
  .a_clr_we     (a_clr_we),
  .b_clr_we     (b_clr_we),
  .stat_a       (stat_a),
  .stat_b       (stat_b),
  .alert_low_en (alert_low_en)
);

// File: tb/test_err_mirror_alert.sv
`timescale 1ns/1ps
module test_err_mirror_alert;
  localparam int NT = 2, NV = 2, NG = 1, NF = 1;
  localparam int W  = NT + NV + NG + NF + 1;   // 7: [1:0] temp [3:2] volt [4] gpi [5] fan [6] trip

  typedef struct packed {
    logic [1:0] te; logic [1:0] ve; logic ge; logic fe; logic tr;
    logic [1:0] sl; logic cm; logic [6:0] mk; logic [8:0] sm;
    logic awe; logic [6:0] ac; logic bwe; logic [6:0] bc;
    logic [6:0] ea; logic [6:0] eb; logic eal; logic [7:0] rq;
  } step_t;

  localparam int NSTEP = 25;
  localparam step_t TBL [NSTEP] = '{
    // te     ve     ge    fe    tr    sl    cm    mk     sm      awe   ac     bwe   bc     ea     eb     al    req
    '{2'b01,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h01,7'h01,1'b1,8'd1}, // R1 thermal event in both
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h01,7'h01,1'b1,8'd5}, // R5 latched
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b1,7'h01,7'h01,7'h00,1'b1,8'd2}, // R2 B clear only
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h01,1'b0,7'h00,7'h00,7'h00,1'b0,8'd5}, // R5 release on A clear
    '{2'b00,2'b01,1'b0,1'b0,1'b0,2'd0,1'b0,7'h04,9'h000,1'b0,7'h00,1'b0,7'h00,7'h04,7'h04,1'b0,8'd4}, // R4 masked recorded
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h04,7'h04,1'b1,8'd4}, // R4 unmask
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h04,1'b1,7'h04,7'h00,7'h00,1'b0,8'd2},
    '{2'b10,2'b00,1'b0,1'b0,1'b0,2'd0,1'b1,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h02,7'h02,1'b1,8'd6}, // R6 live
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b1,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h02,7'h02,1'b0,8'd6}, // R6 follows
    '{2'b00,2'b00,1'b0,1'b1,1'b0,2'd0,1'b1,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h22,7'h22,1'b1,8'd7}, // R7 fan
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b1,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h22,7'h22,1'b1,8'd7}, // R7 latched
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b1,7'h00,9'h000,1'b1,7'h22,1'b1,7'h22,7'h00,7'h00,1'b0,8'd2},
    '{2'b00,2'b00,1'b1,1'b0,1'b1,2'd0,1'b0,7'h40,9'h000,1'b0,7'h00,1'b0,7'h00,7'h50,7'h50,1'b0,8'd8}, // R8 gpi suppressed
    '{2'b00,2'b00,1'b0,1'b0,1'b1,2'd0,1'b0,7'h40,9'h000,1'b0,7'h00,1'b0,7'h00,7'h50,7'h50,1'b0,8'd8},
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h40,9'h000,1'b0,7'h00,1'b0,7'h00,7'h50,7'h50,1'b1,8'd8}, // R8 trip gone
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd2,1'b0,7'h40,9'h008,1'b0,7'h00,1'b0,7'h00,7'h50,7'h50,1'b0,8'd9}, // R9 code 2 gpi
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd1,1'b0,7'h40,9'h008,1'b0,7'h00,1'b0,7'h00,7'h50,7'h50,1'b1,8'd9}, // R9 code 1 set
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h50,1'b1,7'h50,7'h00,7'h00,1'b0,8'd2},
    '{2'b00,2'b10,1'b0,1'b0,1'b0,2'd3,1'b0,7'h00,9'h100,1'b0,7'h00,1'b0,7'h00,7'h08,7'h08,1'b0,8'd9}, // R9 code 3 volt
    '{2'b00,2'b00,1'b0,1'b1,1'b0,2'd3,1'b0,7'h00,9'h100,1'b0,7'h00,1'b0,7'h00,7'h28,7'h28,1'b1,8'd9}, // R9 fan open
    '{2'b00,2'b00,1'b0,1'b1,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h28,1'b0,7'h00,7'h20,7'h28,1'b1,8'd2}, // R2 set wins
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h20,1'b0,7'h00,7'h00,7'h28,1'b0,8'd5}, // R5 B ignored
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b1,7'h28,7'h00,7'h00,1'b0,8'd2},
    '{2'b00,2'b00,1'b0,1'b0,1'b1,2'd0,1'b0,7'h00,9'h000,1'b0,7'h00,1'b0,7'h00,7'h40,7'h40,1'b1,8'd8}, // R8 trip alerts
    '{2'b00,2'b00,1'b0,1'b0,1'b0,2'd0,1'b0,7'h00,9'h000,1'b1,7'h40,1'b1,7'h40,7'h00,7'h00,1'b0,8'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] temp_cond = '0;
  logic [NV-1:0] volt_evt = '0;
  logic [NG-1:0] gpi_evt = '0;
  logic [NF-1:0] fan_evt = '0;
  logic trip_in = 1'b0;
  logic [1:0] sleep_code = '0;
  logic [W-1:0] evt_mask = '0;
  logic [8:0] sleep_mask = '0;
  logic cmp_mode = 1'b0;
  logic a_clr_we = 1'b0, b_clr_we = 1'b0;
  logic [W-1:0] a_clr_bits = '0, b_clr_bits = '0;
  logic [W-1:0] stat_a, stat_b;
  logic alert_low_en;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  err_mirror_alert #(.NT(NT), .NV(NV), .NG(NG), .NF(NF)) i_err_mirror_alert (
    .clk(clk), .rst(rst), .temp_cond(temp_cond), .volt_evt(volt_evt),
    .gpi_evt(gpi_evt), .fan_evt(fan_evt), .trip_in(trip_in),
    .sleep_code(sleep_code), .evt_mask(evt_mask), .sleep_mask(sleep_mask),
    .cmp_mode(cmp_mode), .a_clr_we(a_clr_we), .a_clr_bits(a_clr_bits),
    .b_clr_we(b_clr_we), .b_clr_bits(b_clr_bits), .stat_a(stat_a),
    .stat_b(stat_b), .alert_low_en(alert_low_en));

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  task automatic drive(input step_t s);
    temp_cond = s.te; volt_evt = s.ve; gpi_evt = s.ge; fan_evt = s.fe;
    trip_in = s.tr; sleep_code = s.sl; cmp_mode = s.cm; evt_mask = s.mk;
    sleep_mask = s.sm; a_clr_we = s.awe; a_clr_bits = s.ac;
    b_clr_we = s.bwe; b_clr_bits = s.bc;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(stat_a == '0, "R3 reset stat_a", int'(stat_a), 0);
    chk(stat_b == '0, "R3 reset stat_b", int'(stat_b), 0);
    chk(alert_low_en == 1'b0, "R3 reset alert", int'(alert_low_en), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk(stat_a == TBL[i].ea, $sformatf("R%0d step %0d stat_a", TBL[i].rq, i), int'(stat_a), int'(TBL[i].ea));
      chk(stat_b == TBL[i].eb, $sformatf("R%0d step %0d stat_b", TBL[i].rq, i), int'(stat_b), int'(TBL[i].eb));
      chk(alert_low_en == TBL[i].eal, $sformatf("R%0d step %0d alert", TBL[i].rq, i), int'(alert_low_en), int'(TBL[i].eal));
    end
    idle();
    @(negedge clk);

    // R10: each event input maps to its own bit
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] one;
      one = W'(1) << b;
      {trip_in, fan_evt, gpi_evt, volt_evt, temp_cond} = one;
      evt_mask = '1;
      @(negedge clk);
      chk(stat_a == one, $sformatf("R10 bit %0d stat_a", b), int'(stat_a), int'(one));
      chk(stat_b == one, $sformatf("R10 bit %0d stat_b", b), int'(stat_b), int'(one));
      idle();
      evt_mask = '1;
      a_clr_we = 1'b1; a_clr_bits = '1; b_clr_we = 1'b1; b_clr_bits = '1;
      @(negedge clk);
      idle();
    end

    // R3: reset from a loaded state
    temp_cond = 2'b11; fan_evt = 1'b1;
    @(negedge clk);
    idle();
    chk(alert_low_en == 1'b1, "R3 preload alert", int'(alert_low_en), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(stat_a == '0, "R3 mid reset stat_a", int'(stat_a), 0);
    chk(stat_b == '0, "R3 mid reset stat_b", int'(stat_b), 0);
    chk(alert_low_en == 1'b0, "R3 mid reset alert", int'(alert_low_en), 0);
    rst = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule